// File: doc/BRIEF.md
# Endpoint DMA Sequencer

This block moves data between one chosen device endpoint buffer and an external DMA master. Software programs it through two 16-bit registers. The first is a control word that holds the transfer options, the target endpoint and the enable bit. The second is a byte counter. Writing the counter loads the size of the transfer, and reading it returns the bytes still to move.

Once enabled, the block raises a request and holds it for one burst group. It counts the master's acknowledges until the group's bytes have moved or the count runs out. It then drops the request for at least one cycle before the next group. Each acknowledge moves a word (2 bytes) or a single low byte, as reported by the data path, and the counter goes down by that amount.

The transfer ends with a one-cycle end-of-transfer pulse. Two conditions can raise it: the counter reaching zero, or a short or empty packet on an OUT endpoint. A bus-reset pulse stops the transfer and leaves every other setting as it was.

Top module: `dma_ep_sequencer`

## Requirements
- R1: After reset, both registers read 0 and the request and end-of-transfer outputs are low.
- R2: The control word (reg_sel=0) has this layout: bit 15 count-terminate enable, bit 14 short-packet terminate enable, bit 8 last-access width flag (read-only), bits 7:4 endpoint index, bit 3 run enable, bits 1:0 burst code. All other bits read 0.
- R3: A write with reg_sel=1 loads the byte counter. A read with reg_sel=1 returns the bytes still remaining.
- R4: The burst code sets the group size: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 16. The request rises only while the block is enabled and the count is non-zero. It stays high until the group is used up or the count reaches zero, and it is then low for at least one cycle.
- R5: An acknowledge with ack_word=1 takes 2 from the counter, and one with ack_word=0 takes 1. With a single byte left, a word acknowledge takes only 1, so the counter never wraps.
- R6: With count-terminate set, the acknowledge that brings the counter to zero produces a one-cycle end-of-transfer pulse in the next cycle. In that same cycle the run enable reads 0 and the request is low.
- R7: With count-terminate clear, reaching zero gives no end-of-transfer pulse, the run enable stays 1 and no further request is raised.
- R8: With short-packet terminate set, enabled and ep_is_out=1, a short_pkt pulse produces end-of-transfer in the next cycle and clears the run enable. When ep_is_out=0, the pulse has no effect.
- R9: Writing 0 to the run enable stops the transfer at once. The request goes low and the remaining count is kept.
- R10: A bus_rst pulse clears only the run enable and the request. The counter, the endpoint index, the burst code and both terminate enables keep their values.
- R11: The width flag reads 1 when the last acknowledge moved 2 bytes and 0 when it moved 1.
- R12: ep_sel always shows the endpoint index field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus-reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the byte counter |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register contents (combinational) |
| dreq | output | 1 | Request to the DMA master |
| dack | input | 1 | Acknowledge from the DMA master |
| ack_word | input | 1 | 1 when both bytes of the current access are valid |
| ep_is_out | input | 1 | Selected endpoint is an OUT endpoint |
| short_pkt | input | 1 | Short or empty packet received |
| eot | output | 1 | End-of-transfer pulse |
| ep_sel | output | 4 | Selected endpoint index |

## Verification
A register write takes effect at the next rising edge. The request rises one edge after the write that enables the block, and it falls on the same edge that samples the last acknowledge of a group. End-of-transfer appears one edge after the terminating acknowledge or the short_pkt pulse. The bench drives each input on a falling edge and samples outputs on the following falling edge, half a cycle after the edge that acted. This puts every check in the first cycle where the result must hold. A check one cycle later confirms that the end-of-transfer pulse lasts a single cycle.

// File: rtl/dma_ep_sequencer.sv
module dma_ep_sequencer #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rst,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        dreq,
  input  logic        dack,
  input  logic        ack_word,
  input  logic        ep_is_out,
  input  logic        short_pkt,
  output logic        eot,
  output logic [3:0]  ep_sel
);
  localparam int GW = 5;

  logic             cnt_en, short_en, odd_even, en, in_grp, eot_q;
  logic [3:0]       ep;
  logic [1:0]       burst;
  logic [CNT_W-1:0] count;
  logic [GW-1:0]    grp_left;

  logic [2:0]       bshift;
  logic [GW-1:0]    burst_bytes;
  logic             ack, last_cnt, grp_done, eot_set;
  logic [CNT_W-1:0] dec;

  assign bshift      = (burst == 2'd0) ? 3'd0 : {1'b0, burst} + 3'd1;
  assign burst_bytes = GW'(1) << bshift;
  assign ack         = in_grp && dack;
  assign dec         = (ack_word && count >= CNT_W'(2)) ? CNT_W'(2) : CNT_W'(1);
  assign last_cnt    = ack && (count == dec);
  assign grp_done    = ack && ((CNT_W'(grp_left) <= dec) || last_cnt);
  assign eot_set     = en && ((cnt_en && last_cnt) || (short_en && ep_is_out && short_pkt));

  assign dreq   = in_grp;
  assign eot    = eot_q;
  assign ep_sel = ep;

  always_comb begin
    if (reg_sel) reg_rdata = 16'(count);
    else         reg_rdata = {cnt_en, short_en, 5'b0, odd_even, ep, en, 1'b0, burst};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en   <= 1'b0;
      short_en <= 1'b0;
      odd_even <= 1'b0;
      en       <= 1'b0;
      in_grp   <= 1'b0;
      eot_q    <= 1'b0;
      ep       <= '0;
      burst    <= '0;
      count    <= '0;
      grp_left <= '0;
    end else begin
      eot_q <= 1'b0;
      if (bus_rst) begin
        en     <= 1'b0;
        in_grp <= 1'b0;
      end else begin
        if (ack) begin
          count    <= count - dec;
          odd_even <= (dec == CNT_W'(2));
          grp_left <= grp_left - dec[GW-1:0];
          if (grp_done) in_grp <= 1'b0;
        end else if (en && !in_grp && count != '0) begin
          in_grp   <= 1'b1;
          grp_left <= burst_bytes;
        end
        if (reg_wr && reg_sel) count <= CNT_W'(reg_wdata);
        if (reg_wr && !reg_sel) begin
          cnt_en   <= reg_wdata[15];
          short_en <= reg_wdata[14];
          ep       <= reg_wdata[7:4];
          en       <= reg_wdata[3];
          burst    <= reg_wdata[1:0];
          if (!reg_wdata[3]) in_grp <= 1'b0;
        end
        if (eot_set) begin
          eot_q  <= 1'b1;
          en     <= 1'b0;
          in_grp <= 1'b0;
        end
      end
    end
  end

  // R5
  count_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel) |=> count <= $past(count));

  // R6
  eot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot);

  // R6
  eot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> (!en && !dreq));

  // R9
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> en);

  // R10
  bus_rst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (!en && !dreq));

  // R7
  req_needs_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> count != '0);
endmodule

// File: tb/dma_ep_sequencer_tb.sv
module dma_ep_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dreq;
  logic        dack = 1'b0;
  logic        ack_word = 1'b0;
  logic        ep_is_out = 1'b0;
  logic        short_pkt = 1'b0;
  logic        eot;
  logic [3:0]  ep_sel;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  dma_ep_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
    .ack_word(ack_word), .ep_is_out(ep_is_out), .short_pkt(short_pkt),
    .eot(eot), .ep_sel(ep_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [15:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  function automatic bit wfun(input int mode, input int k);
    if (mode == 0) return 1'b0;
    if (mode == 1) return 1'b1;
    return (k % 2) == 0;
  endfunction

  task automatic ack_n(input int n, input bit w);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      if (dreq) begin dack = 1'b1; ack_word = w; got++; end
      else dack = 1'b0;
    end
    @(negedge clk);
    dack = 1'b0;
  endtask

  task automatic run_xfer(input int b, input int n, input int mode);
    int exp_g[64];
    int got_g[64];
    int ng = 0, gi = 0, run = 0, k = 0, cyc = 0, rem, bsz, gl, d, a, mism;
    bit exp_odd = 1'b0, seen = 1'b0, done;
    logic [15:0] v;
    bsz = (b == 0) ? 1 : (1 << (b + 1));
    rem = n;
    while (rem > 0) begin
      gl = bsz; a = 0; done = 1'b0;
      while (!done) begin
        d = (wfun(mode, k) && rem >= 2) ? 2 : 1;
        exp_odd = (d == 2);
        rem -= d; k++; a++;
        done = (d >= gl) || (rem == 0);
        gl -= d;
      end
      exp_g[ng] = a; ng++;
    end
    wr(1'b1, 16'(n));
    wr(1'b0, 16'h8058 | 16'(b));
    k = 0;
    while (!seen && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (eot) seen = 1'b1;
      if (dreq) begin
        dack = 1'b1; ack_word = wfun(mode, k); k++; run++;
      end else begin
        dack = 1'b0;
        if (run > 0) begin
          if (gi < 64) got_g[gi] = run;
          gi++; run = 0;
        end
      end
    end
    dack = 1'b0;
    mism = (gi != ng) ? 1 : 0;
    for (int i = 0; i < ng && i < gi; i++) if (got_g[i] != exp_g[i]) mism++;
    chk(mism == 0, $sformatf("R4 groups b=%0d n=%0d m=%0d", b, n, mode), gi, ng);
    chk(seen, $sformatf("R6 eot seen b=%0d n=%0d m=%0d", b, n, mode), int'(seen), 1);
    rd(1'b1, v);
    chk(v == 16'h0, $sformatf("R3 R5 count end n=%0d m=%0d", n, mode), int'(v), 0);
    rd(1'b0, v);
    chk(v == (16'h8050 | 16'(b) | (exp_odd ? 16'h0100 : 16'h0)),
        $sformatf("R2 R6 R11 cfg b=%0d n=%0d m=%0d", b, n, mode),
        int'(v), int'(16'h8050 | 16'(b) | (exp_odd ? 16'h0100 : 16'h0)));
    chk(ep_sel == 4'd5, "R12 ep_sel", int'(ep_sel), 5);
    @(negedge clk);
    chk(!eot && !dreq, "R6 eot single pulse", int'({eot, dreq}), 0);
  endtask

  initial begin
    logic [15:0] v;
    int acks;
    bit e;
    int ns[12] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 16, 17, 33};
    #(CLK_PERIOD * 2 + 1);
    rd(1'b0, v);
    chk(v == 16'h0 && !dreq && !eot, "R1 cfg reset", int'(v), 0);
    rd(1'b1, v);
    chk(v == 16'h0, "R1 count reset", int'(v), 0);
    rst_n = 1'b1;

    wr(1'b0, 16'hFFFF);
    rd(1'b0, v);
    chk(v == 16'hC0FB, "R2 reserved zero", int'(v), int'(16'hC0FB));
    chk(ep_sel == 4'hF, "R12 ep_sel all ones", int'(ep_sel), 15);
    @(negedge clk);
    chk(!dreq, "R4 no request at zero count", int'(dreq), 0);
    wr(1'b0, 16'h0000);

    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 12; i++)
        for (int m = 0; m < 3; m++)
          run_xfer(b, ns[i], m);

    // R7: count-terminate clear
    wr(1'b1, 16'd3);
    wr(1'b0, 16'h0009);
    acks = 0; e = 1'b0;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      if (eot) e = 1'b1;
      if (dreq) begin dack = 1'b1; ack_word = 1'b0; acks++; end
      else dack = 1'b0;
    end
    dack = 1'b0;
    chk(acks == 3, "R7 acks", acks, 3);
    chk(!e, "R7 no eot", int'(e), 0);
    chk(!dreq, "R7 no request", int'(dreq), 0);
    rd(1'b0, v);
    chk(v[3] == 1'b1, "R7 enable kept", int'(v[3]), 1);
    wr(1'b0, 16'h0000);

    // R9: stop by writing zero
    wr(1'b1, 16'd20);
    wr(1'b0, 16'h0008);
    ack_n(2, 1'b0);
    wr(1'b0, 16'h0000);
    chk(!dreq && !eot, "R9 request dropped", int'(dreq), 0);
    rd(1'b1, v);
    chk(v == 16'd18, "R9 count kept", int'(v), 18);

    // R8: short packet on OUT endpoint
    wr(1'b1, 16'd40);
    wr(1'b0, 16'h4008);
    ep_is_out = 1'b1;
    ack_n(3, 1'b0);
    short_pkt = 1'b1;
    @(negedge clk);
    short_pkt = 1'b0;
    chk(eot == 1'b1, "R8 short eot", int'(eot), 1);
    rd(1'b1, v);
    chk(v == 16'd37, "R8 count left", int'(v), 37);
    rd(1'b0, v);
    chk(v[3] == 1'b0, "R8 enable cleared", int'(v[3]), 0);

    // R8: IN endpoint ignores short packet
    wr(1'b1, 16'd40);
    wr(1'b0, 16'h4008);
    ep_is_out = 1'b0;
    @(negedge clk);
    short_pkt = 1'b1;
    @(negedge clk);
    short_pkt = 1'b0;
    chk(!eot, "R8 IN ignored eot", int'(eot), 0);
    rd(1'b0, v);
    chk(v[3] == 1'b1, "R8 IN enable kept", int'(v[3]), 1);
    rd(1'b1, v);
    chk(v == 16'd40, "R8 IN count kept", int'(v), 40);
    wr(1'b0, 16'h0000);

    // R10: bus reset
    wr(1'b1, 16'd50);
    wr(1'b0, 16'hC0AA);
    @(negedge clk);
    chk(dreq == 1'b1, "R4 request raised", int'(dreq), 1);
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    chk(!dreq, "R10 request cleared", int'(dreq), 0);
    rd(1'b0, v);
    chk((v & 16'hFEFF) == 16'hC0A2, "R10 fields kept", int'(v & 16'hFEFF), int'(16'hC0A2));
    rd(1'b1, v);
    chk(v == 16'd50, "R10 count kept", int'(v), 50);
    chk(ep_sel == 4'hA, "R12 ep_sel kept", int'(ep_sel), 10);
    @(negedge clk);
    chk(!dreq, "R10 stays stopped", int'(dreq), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule